// File: doc/BRIEF.md
# Two-Level Nanomemory Control Store

This block supplies control words to a microprogrammed datapath from a two-level store. The first level, the microprogram store, has one short entry for each microprogram step. That entry is an index into the second level, the nanomemory, which holds every distinct wide control word once. Storing a word once saves space when the same control word is used at many steps. The cost is that every step needs two dependent reads.

A sequencer presents a step address with a strobe. The block reads the index in one clock cycle and looks up the wide word in the next. The word is registered and appears on the output together with a valid flag. One step can be accepted on every cycle.

Both stores are read-only and take their contents from packed parameter vectors.
- The index width defaults to the smallest width that can address the nanomemory, with a minimum of one bit.
- Elaboration stops with an error if the index width cannot address every nanomemory entry.
- The default configuration is a 7-step microprogram of 2-bit indices feeding a 3-entry nanomemory of 4-bit words. That is 26 bits of storage, against 28 bits for a single-level store.

Top module: `nano_ctrl_store`

## Requirements
- R1: `cw_vld_o` is high at a rising edge exactly when `step_vld_i` was high at the rising edge two edges earlier. Back-to-back steps give back-to-back valid words.
- R2: For a valid step, `cw_o` equals the nanomemory entry whose number is the index stored at that step address. Entry i of either store occupies bits [i*W +: W] of its init parameter, where W is that store's entry width.
- R3: A stored index equal to or greater than `WORDS` gives an all-zero control word with `cw_vld_o` high. In the default contents, step 5 holds index 3.
- R4: A step address equal to or greater than `STEPS` gives an all-zero control word with `cw_vld_o` high. In the default configuration this is address 7.
- R5: `cw_o` is all zero whenever `cw_vld_o` is low.
- R6: `rst_ni` low asynchronously clears both pipeline stages, so `cw_vld_o` and `cw_o` read zero. A step accepted just before reset never appears after reset.
- R7: A value on `step_addr_i` while `step_vld_i` is low has no effect: the output two edges later is invalid and zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_vld_i | input | 1 | A step address is presented this cycle |
| step_addr_i | input | SA_W | Microprogram step address |
| cw_o | output | CW_W | Registered control word |
| cw_vld_o | output | 1 | Control word valid, two cycles after the step |

## Verification
A wrong index register, or a wrong index-to-word path, shows as a wrong word on `cw_o` exactly two edges after the step that used it. The random address stream covers every step, so any corrupted index or nanomemory entry is exposed within a few hundred cycles.

A slip in the valid pipeline shows as `cw_vld_o` one cycle early or late, or as a nonzero word while the output is idle. Both are visible on the first step that follows an idle gap.

A reset that clears only one stage leaks a pre-reset step out within two edges of reset release.

// File: rtl/ns_pkg.sv
package ns_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ns_mprog_stage.sv
module ns_mprog_stage #(
  parameter int STEPS = 7,
  parameter int IDX_W = 2,
  parameter int SA_W  = 3,
  parameter logic [STEPS*IDX_W-1:0] MPROG_INIT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [SA_W-1:0]  addr_i,
  output logic             vld_o,
  output logic             ok_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [SA_W:0] STEPS_W = (SA_W+1)'(STEPS);

  logic [IDX_W-1:0] rom [STEPS];
  for (genvar g = 0; g < STEPS; g++) begin : g_rom
    assign rom[g] = MPROG_INIT[g*IDX_W +: IDX_W];
  end

  logic             in_rng;
  logic [IDX_W-1:0] idx_d;
  always_comb begin
    in_rng = {1'b0, addr_i} < STEPS_W;
    idx_d  = in_rng ? rom[addr_i] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      ok_o  <= 1'b0;
      idx_o <= '0;
    end else begin
      vld_o <= vld_i;
      ok_o  <= vld_i & in_rng;
      idx_o <= vld_i ? idx_d : '0;
    end
  end
endmodule

// File: rtl/ns_nano_stage.sv
module ns_nano_stage #(
  parameter int WORDS = 3,
  parameter int CW_W  = 4,
  parameter int IDX_W = 2,
  parameter logic [WORDS*CW_W-1:0] NANO_INIT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             ok_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             vld_o,
  output logic [CW_W-1:0]  cw_o
);
  localparam logic [IDX_W:0] WORDS_W = (IDX_W+1)'(WORDS);

  logic [CW_W-1:0] rom [WORDS];
  for (genvar g = 0; g < WORDS; g++) begin : g_rom
    assign rom[g] = NANO_INIT[g*CW_W +: CW_W];
  end

  logic            hit;
  logic [CW_W-1:0] cw_d;
  always_comb begin
    hit  = ok_i && ({1'b0, idx_i} < WORDS_W);
    cw_d = hit ? rom[idx_i] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      cw_o  <= '0;
    end else begin
      vld_o <= vld_i;
      cw_o  <= vld_i ? cw_d : '0;
    end
  end
endmodule

// File: rtl/nano_ctrl_store.sv
module nano_ctrl_store #(
  parameter int STEPS = 7,
  parameter int WORDS = 3,
  parameter int CW_W  = 4,
  parameter int IDX_W = ns_pkg::idx_width(WORDS),
  parameter int SA_W  = ns_pkg::idx_width(STEPS),
  parameter logic [STEPS*IDX_W-1:0] MPROG_INIT = 14'b10_11_01_00_10_01_00,
  parameter logic [WORDS*CW_W-1:0]  NANO_INIT  = 12'hC5A
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_vld_i,
  input  logic [SA_W-1:0] step_addr_i,
  output logic [CW_W-1:0] cw_o,
  output logic            cw_vld_o
);
  if (WORDS > (1 << IDX_W)) begin : g_idx_chk
    $error("IDX_W too narrow for WORDS");
  end

  logic             s1_vld, s1_ok;
  logic [IDX_W-1:0] s1_idx;

  ns_mprog_stage #(
    .STEPS(STEPS), .IDX_W(IDX_W), .SA_W(SA_W), .MPROG_INIT(MPROG_INIT)
  ) u_mprog (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(step_vld_i), .addr_i(step_addr_i),
    .vld_o(s1_vld), .ok_o(s1_ok), .idx_o(s1_idx)
  );

  ns_nano_stage #(
    .WORDS(WORDS), .CW_W(CW_W), .IDX_W(IDX_W), .NANO_INIT(NANO_INIT)
  ) u_nano (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(s1_vld), .ok_i(s1_ok), .idx_i(s1_idx),
    .vld_o(cw_vld_o), .cw_o(cw_o)
  );
endmodule

// File: rtl/ns_chk.sv
module ns_chk #(
  parameter int STEPS = 7,
  parameter int WORDS = 3,
  parameter int CW_W  = 4,
  parameter int IDX_W = 2,
  parameter int SA_W  = 3,
  parameter logic [STEPS*IDX_W-1:0] MPROG_INIT = '0,
  parameter logic [WORDS*CW_W-1:0]  NANO_INIT  = '0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            step_vld_i,
  input logic [SA_W-1:0] step_addr_i,
  input logic [CW_W-1:0] cw_o,
  input logic            cw_vld_o
);
  function automatic logic [CW_W-1:0] ref_word(input logic [SA_W-1:0] a);
    int ix;
    if (int'(a) >= STEPS) return '0;
    ix = int'(MPROG_INIT[int'(a)*IDX_W +: IDX_W]);
    if (ix >= WORDS) return '0;
    return NANO_INIT[ix*CW_W +: CW_W];
  endfunction

  logic [1:0] live_q;
  logic       seen_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= '0;
    else if (live_q != 2'd2) live_q <= live_q + 2'd1;
  end
  always_ff @(posedge clk_i) seen_rst_q <= seen_rst_q | !rst_ni;

  // R6
  always_ff @(posedge clk_i) begin
    if (seen_rst_q && !rst_ni) begin
      rst_clear_chk: assert (!cw_vld_o && cw_o == '0);
    end
  end

  // R1
  vld_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q == 2'd2 |-> cw_vld_o == $past(step_vld_i, 2));

  // R2 R3
  word_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q == 2'd2 && $past(step_vld_i, 2)) |-> cw_o == ref_word($past(step_addr_i, 2)));

  // R4
  step_oob_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q == 2'd2 && $past(step_vld_i, 2) && int'($past(step_addr_i, 2)) >= STEPS)
      |-> (cw_vld_o && cw_o == '0));

  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cw_vld_o |-> cw_o == '0);

  // R7
  no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q == 2'd2 && !$past(step_vld_i, 2)) |-> (!cw_vld_o && cw_o == '0));
endmodule

bind nano_ctrl_store ns_chk #(
  .STEPS(STEPS), .WORDS(WORDS), .CW_W(CW_W), .IDX_W(IDX_W), .SA_W(SA_W),
  .MPROG_INIT(MPROG_INIT), .NANO_INIT(NANO_INIT)
) u_ns_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_vld_i(step_vld_i), .step_addr_i(step_addr_i),
  .cw_o(cw_o), .cw_vld_o(cw_vld_o)
);

// File: tb/tb_nano_ctrl_store.sv
module tb_nano_ctrl_store;
  localparam int STEPS = 7;
  localparam int WORDS = 3;
  localparam int CW_W  = 4;
  localparam int IDX_W = 2;
  localparam int SA_W  = 3;
  // indices per step 0..6: 0,1,2,0,1,3,2 ; words: A,5,C
  localparam logic [STEPS*IDX_W-1:0] MP = 14'b10_11_01_00_10_01_00;
  localparam logic [WORDS*CW_W-1:0]  NM = 12'hC5A;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            step_vld_i = 1'b0;
  logic [SA_W-1:0] step_addr_i = '0;
  logic [CW_W-1:0] cw_o;
  logic            cw_vld_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  nano_ctrl_store #(
    .STEPS(STEPS), .WORDS(WORDS), .CW_W(CW_W), .MPROG_INIT(MP), .NANO_INIT(NM)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_vld_i(step_vld_i), .step_addr_i(step_addr_i),
    .cw_o(cw_o), .cw_vld_o(cw_vld_o)
  );

  always #2 clk_i = ~clk_i;

  function automatic logic [CW_W-1:0] exp_word(input logic [SA_W-1:0] a);
    int ix;
    if (int'(a) >= STEPS) return '0;
    ix = int'(MP[int'(a)*IDX_W +: IDX_W]);
    if (ix >= WORDS) return '0;
    return NM[ix*CW_W +: CW_W];
  endfunction

  function automatic string tag_of(input logic v, input logic [SA_W-1:0] a, input bit pr);
    if (pr) return "R6";
    if (!v) return "R7";
    if (int'(a) >= STEPS) return "R4";
    if (int'(MP[int'(a)*IDX_W +: IDX_W]) >= WORDS) return "R3";
    return "R2";
  endfunction

  task automatic chk(input string rq, input logic [CW_W:0] act, input logic [CW_W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act vld/cw=%h exp=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // model pipeline: h1 newest, h2 due at this negedge
  logic            h1_v, h2_v;
  logic [SA_W-1:0] h1_a, h2_a;
  bit              h1_r, h2_r;

  task automatic step(input logic v, input logic [SA_W-1:0] a);
    @(negedge clk_i);
    chk(h2_v ? "R1" : tag_of(h2_v, h2_a, h2_r), {cw_vld_o, 4'h0}, {h2_v, 4'h0});
    chk(tag_of(h2_v, h2_a, h2_r), {1'b0, cw_o}, {1'b0, h2_v ? exp_word(h2_a) : 4'h0});
    if (!cw_vld_o) chk("R5", {1'b0, cw_o}, '0);
    h2_v = h1_v; h2_a = h1_a; h2_r = h1_r;
    h1_v = v;    h1_a = a;    h1_r = 1'b0;
    step_vld_i  = v;
    step_addr_i = a;
  endtask

  task automatic mid_reset();
    @(negedge clk_i);
    step_vld_i = 1'b1; step_addr_i = 3'd0;
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R6", {cw_vld_o, cw_o}, '0);
    step_vld_i = 1'b0;
    @(negedge clk_i);
    chk("R6", {cw_vld_o, cw_o}, '0);
    rst_ni = 1'b1;
    h1_v = 0; h2_v = 0; h1_r = 1; h2_r = 1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    h1_v = 0; h2_v = 0; h1_a = '0; h2_a = '0; h1_r = 1; h2_r = 1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R6", {cw_vld_o, cw_o}, '0);
    rst_ni = 1'b1;
    // R2 R3 R4: every address back to back
    for (int i = 0; i < 8; i++) step(1'b1, SA_W'(i));
    // R7: address changes with strobe low
    for (int i = 0; i < 8; i++) step(1'b0, SA_W'(7 - i));
    // R1: isolated single steps
    step(1'b1, 3'd2); step(1'b0, 3'd2); step(1'b0, 3'd5); step(1'b1, 3'd5);
    step(1'b0, 3'd0); step(1'b0, 3'd0);
    mid_reset();
    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, SA_W'($urandom % 8));
    mid_reset();
    for (int i = 0; i < 500; i++) step(($urandom % 2) != 0, SA_W'($urandom % 8));
    step(1'b0, '0); step(1'b0, '0); step(1'b0, '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule